// File: doc/BRIEF.md
# Two-Wire Serial Programming Target

This block is the device-side end of a clocked two-wire programming port. The host supplies a programming clock on one pin. Data moves in both directions on a second pin. A third input reports that the reset pin sits at its high programming voltage. The block watches that input to decide when programming mode starts and ends.

While in programming mode, the block receives short command codes and, for the data commands, one framed data word. It runs each command against a small register-based program memory of 14-bit words:

- write a word,
- read a word,
- advance the word address,
- erase the whole memory,
- leave programming mode.

For a read, the block turns the data pin around and drives the stored word back to the host.

All pin inputs pass through synchronisers into the system clock domain. Bits are taken on the falling edge of the programming clock. A data-pin change only counts after it has been stable for a set number of system clocks, which models the minimum setup time.

Top module: `twsp_target`

## Requirements
- R1: Programming mode starts only when the synchronised `hv_sense` rises while `prog_clk` and `sdat_in` are both low. A rise at any other moment leaves the block outside programming mode, where commands have no effect.
- R2: A command is a 6-bit code taken least significant bit first, one bit per falling edge of `prog_clk`. The codes are: 6'h02 write, 6'h04 read, 6'h06 advance address, 6'h09 erase, 6'h11 leave.
- R3: The write and read codes are each followed by a 16-clock frame sent LSB first. Frame bit 0 is a start bit, bits 1 to 14 are the payload, and bit 15 is a stop bit. For a write, the payload is stored at the current word address after the sixteenth edge.
- R4: For a read, `sdat_oe` is high only during data clocks 2 to 15, counting from 1. During data clock k+2, `sdat_out` carries bit k of the word at the current address. `sdat_oe` is low during data clocks 1 and 16.
- R5: The advance-address code increments the word address. From the last word (2**AW-1) it wraps to 0.
- R6: Every word holds 14'h3FFF after reset and after the erase code.
- R7: A fall of `hv_sense` ends programming mode at once and releases the pin. Each new entry sets the word address to 0.
- R8: The leave code ends programming mode. Further commands have no effect until a new entry.
- R9: An undefined code has no effect and no data frame follows it. The next six clocks form a new command.
- R10: If `sdat_in` changes fewer than SETUP_CYC system clocks before a falling edge, the bit taken on that edge is the previous stable value.
- R11: Out of reset, the block is outside programming mode and `sdat_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_clk | input | 1 | Programming clock from the host |
| hv_sense | input | 1 | High when the reset pin is at programming voltage |
| sdat_in | input | 1 | Data pin, input side |
| sdat_out | output | 1 | Data pin, output side |
| sdat_oe | output | 1 | Data pin output enable |

## Verification
The assertions check four things on every cycle:

- the pin is driven only in programming mode;
- a mode start always follows a low clock and a low data line;
- a voltage drop ends the mode and releases the pin on the next cycle;
- the address wraps, and the memory ends up in its erased value after the erase command.

The bench's scenarios are the only way to show the serial behaviour. This covers bit order, frame payload placement, the exact output-enable window, and the skipping of unknown codes. It also covers the rejection of late data changes and of badly timed entries, which only show up in the word a later read returns.

// File: rtl/twsp_target.sv
module twsp_target #(
  parameter int AW        = 4,
  parameter int SYNC      = 2,
  parameter int SETUP_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_clk,
  input  logic hv_sense,
  input  logic sdat_in,
  output logic sdat_out,
  output logic sdat_oe
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(SETUP_CYC + 1);
  localparam logic [5:0] OP_LOAD  = 6'h02;
  localparam logic [5:0] OP_READ  = 6'h04;
  localparam logic [5:0] OP_INC   = 6'h06;
  localparam logic [5:0] OP_ERASE = 6'h09;
  localparam logic [5:0] OP_EXIT  = 6'h11;
  localparam logic [13:0] ERASED  = 14'h3FFF;

  typedef enum logic [1:0] {S_OFF, S_CMD, S_DATA} st_t;

  logic [SYNC-1:0] pc_sh, dt_sh, hv_sh;
  logic pc_s, dt_s, hv_s, pc_q, hv_q, dat_f;
  logic [CW-1:0] fcnt;
  st_t st;
  logic [3:0] bcnt;
  logic [15:0] sr;
  logic rd_op;
  logic [AW-1:0] addr;
  logic [13:0] rword;
  logic [13:0] mem [DEPTH];

  assign pc_s = pc_sh[SYNC-1];
  assign dt_s = dt_sh[SYNC-1];
  assign hv_s = hv_sh[SYNC-1];

  wire fall    = pc_q & ~pc_s;
  wire hv_rise = hv_s & ~hv_q;
  wire hv_fall = ~hv_s & hv_q;
  wire [5:0]  code  = {dat_f, sr[15:11]};
  wire [15:0] frame = {dat_f, sr[15:1]};
  wire cmd_go   = fall && !hv_fall && st == S_CMD && bcnt == 4'd5;
  wire frame_go = fall && !hv_fall && st == S_DATA && bcnt == 4'd15;
  wire erase_go = cmd_go && code == OP_ERASE;
  wire inc_go   = cmd_go && code == OP_INC;
  wire in_mode  = st != S_OFF;

  assign sdat_oe  = st == S_DATA && rd_op && bcnt != 4'd0 && bcnt != 4'd15;
  assign sdat_out = sdat_oe & rword[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_sh <= '0; dt_sh <= '0; hv_sh <= '0;
      pc_q <= 1'b0; hv_q <= 1'b0;
      dat_f <= 1'b0; fcnt <= '0;
    end else begin
      pc_sh <= {pc_sh[SYNC-2:0], prog_clk};
      dt_sh <= {dt_sh[SYNC-2:0], sdat_in};
      hv_sh <= {hv_sh[SYNC-2:0], hv_sense};
      pc_q  <= pc_s;
      hv_q  <= hv_s;
      if (dt_s == dat_f) fcnt <= '0;
      else if (fcnt == CW'(SETUP_CYC - 1)) begin
        dat_f <= dt_s;
        fcnt  <= '0;
      end else fcnt <= fcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OFF; bcnt <= '0; sr <= '0; rd_op <= 1'b0;
      addr <= '0; rword <= '0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= ERASED;
    end else if (hv_fall) begin
      st <= S_OFF;
      rd_op <= 1'b0;
    end else if (st == S_OFF) begin
      if (hv_rise && !pc_s && !dt_s) begin
        st <= S_CMD;
        bcnt <= '0;
        addr <= '0;
      end
    end else if (fall) begin
      sr <= {dat_f, sr[15:1]};
      if (st == S_CMD) begin
        if (cmd_go) begin
          bcnt <= '0;
          case (code)
            OP_LOAD: begin st <= S_DATA; rd_op <= 1'b0; end
            OP_READ: begin st <= S_DATA; rd_op <= 1'b1; rword <= mem[addr]; end
            OP_INC:  addr <= addr + 1'b1;
            OP_ERASE: for (int k = 0; k < DEPTH; k++) mem[k] <= ERASED;
            OP_EXIT: st <= S_OFF;
            default: ;
          endcase
        end else bcnt <= bcnt + 1'b1;
      end else begin
        if (rd_op && bcnt != 4'd0) rword <= rword >> 1;
        if (frame_go) begin
          bcnt <= '0;
          st <= S_CMD;
          if (!rd_op) mem[addr] <= frame[14:1];
          rd_op <= 1'b0;
        end else bcnt <= bcnt + 1'b1;
      end
    end
  end

  p_entry_cond_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_mode) |-> $past(!pc_s && !dt_s && hv_s));
  p_oe_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sdat_oe |-> in_mode);
  p_addr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_go && addr == AW'(DEPTH - 1)) |=> addr == '0);
  p_erase_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> (mem[0] == ERASED && mem[DEPTH-1] == ERASED));
  p_exit_hv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hv_fall |=> (!in_mode && !sdat_oe));
  p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_mode |-> !sdat_oe);
endmodule

// File: tb/twsp_target_test.sv
module twsp_target_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic prog_clk = 1'b0, hv_sense = 1'b0, sdat_in = 1'b0;
  logic sdat_out, sdat_oe;
  int checks = 0, errors = 0;
  localparam int HALF = 30;

  twsp_target uut (.clk(clk), .rst_n(rst_n), .prog_clk(prog_clk), .hv_sense(hv_sense),
                   .sdat_in(sdat_in), .sdat_out(sdat_out), .sdat_oe(sdat_oe));

  always #2.5 clk = ~clk;

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    sdat_in = b; prog_clk = 1'b1; wt(HALF);
    prog_clk = 1'b0; wt(HALF);
  endtask

  task automatic send_cmd(input logic [5:0] c);
    for (int i = 0; i < 6; i++) pulse(c[i]);
  endtask

  task automatic load(input logic [13:0] w);
    logic [15:0] f;
    f = {1'b0, w, 1'b0};
    send_cmd(6'h02);
    for (int i = 0; i < 16; i++) pulse(f[i]);
  endtask

  task automatic rd(output logic [13:0] w, output logic [15:0] oev);
    w = '0; oev = '0;
    send_cmd(6'h04);
    for (int j = 0; j < 16; j++) begin
      sdat_in = 1'b0; prog_clk = 1'b1; wt(HALF);
      oev[j] = sdat_oe;
      if (j >= 1 && j <= 14) w[j-1] = sdat_out;
      prog_clk = 1'b0; wt(HALF);
    end
  endtask

  task automatic enter();
    hv_sense = 1'b0; prog_clk = 1'b0; sdat_in = 1'b0; wt(10);
    hv_sense = 1'b1; wt(10);
  endtask

  task automatic leave_hv();
    hv_sense = 1'b0; wt(10);
  endtask

  task automatic t_reset();
    logic [13:0] w; logic [15:0] v;
    chk(sdat_oe == 1'b0, "R11 oe after reset", sdat_oe, 0);
    rd(w, v);
    chk(v == 16'h0, "R11 no drive before entry", v, 0);
  endtask

  task automatic t_erased_read();
    logic [13:0] w; logic [15:0] v;
    enter();
    rd(w, v);
    chk(v == 16'h7FFE, "R4 oe window", v, 16'h7FFE);
    chk(w == 14'h3FFF, "R6 reset contents", w, 14'h3FFF);
  endtask

  task automatic t_load_read();
    logic [13:0] w; logic [15:0] v;
    load(14'h2A5C);
    rd(w, v);
    chk(w == 14'h2A5C, "R3 write then read", w, 14'h2A5C);
    chk(v == 16'h7FFE, "R4 oe window again", v, 16'h7FFE);
    load(14'h0001);
    rd(w, v);
    chk(w == 14'h0001, "R2 R3 lsb first payload", w, 14'h0001);
  endtask

  task automatic t_inc_wrap();
    logic [13:0] w; logic [15:0] v;
    load(14'h1111);
    send_cmd(6'h06);
    load(14'h2222);
    rd(w, v);
    chk(w == 14'h2222, "R5 next address", w, 14'h2222);
    for (int i = 0; i < 15; i++) send_cmd(6'h06);
    rd(w, v);
    chk(w == 14'h1111, "R5 wrap to zero", w, 14'h1111);
  endtask

  task automatic t_undef();
    logic [13:0] w; logic [15:0] v;
    send_cmd(6'h3F);
    rd(w, v);
    chk(w == 14'h1111 && v == 16'h7FFE, "R9 undefined code skipped", w, 14'h1111);
  endtask

  task automatic t_setup();
    logic [13:0] w; logic [15:0] v;
    send_cmd(6'h02);
    pulse(1'b0);
    sdat_in = 1'b0; prog_clk = 1'b1; wt(HALF - 3);
    sdat_in = 1'b1; wt(3);
    prog_clk = 1'b0; wt(HALF);
    for (int i = 2; i < 16; i++) pulse(1'b1);
    rd(w, v);
    chk(w == 14'h3FFE, "R10 late change ignored", w, 14'h3FFE);
  endtask

  task automatic t_erase();
    logic [13:0] w; logic [15:0] v;
    send_cmd(6'h09);
    rd(w, v);
    chk(w == 14'h3FFF, "R6 erase addr0", w, 14'h3FFF);
    send_cmd(6'h06);
    rd(w, v);
    chk(w == 14'h3FFF, "R6 erase addr1", w, 14'h3FFF);
  endtask

  task automatic t_hv_exit();
    logic [13:0] w; logic [15:0] v;
    load(14'h0ABC);
    leave_hv();
    rd(w, v);
    chk(v == 16'h0, "R7 no drive after voltage drop", v, 0);
    enter();
    load(14'h0123);
    send_cmd(6'h06);
    rd(w, v);
    chk(w == 14'h0ABC, "R7 address reset on entry", w, 14'h0ABC);
  endtask

  task automatic t_bad_entry();
    logic [13:0] w; logic [15:0] v;
    leave_hv();
    prog_clk = 1'b1; wt(10); hv_sense = 1'b1; wt(10); prog_clk = 1'b0; wt(10);
    rd(w, v);
    chk(v == 16'h0, "R1 entry with clock high rejected", v, 0);
    leave_hv();
    sdat_in = 1'b1; wt(10); hv_sense = 1'b1; wt(10); sdat_in = 1'b0; wt(10);
    rd(w, v);
    chk(v == 16'h0, "R1 entry with data high rejected", v, 0);
  endtask

  task automatic t_exit_cmd();
    logic [13:0] w; logic [15:0] v;
    enter();
    rd(w, v);
    chk(v == 16'h7FFE, "R1 valid entry", v, 16'h7FFE);
    send_cmd(6'h11);
    rd(w, v);
    chk(v == 16'h0, "R8 leave code", v, 0);
  endtask

  initial begin
    wt(5); rst_n = 1'b1; wt(5);
    t_reset();
    t_erased_read();
    t_load_read();
    t_inc_wrap();
    t_undef();
    t_setup();
    t_erase();
    t_hv_exit();
    t_bad_entry();
    t_exit_cmd();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule